// File: doc/BRIEF.md
# Sample Rate Decimator with Format Stage

This block takes one 32-bit sample word per cycle, qualified by a valid strobe. It lowers the sample rate by a programmable divisor and reshapes each value before it leaves. Two rate reduction styles are available. In the first, the block keeps one word out of each group of N valid words and drops the rest. In the second, it adds up the N words of each group and scales the sum down by a right shift.

Formatting happens before decimation. When signed handling is on, every bit above a programmable sign position takes the value of the bit at that position. In half-word mode, each input word carries two independent 16-bit samples. The sign position, the averaging and the lane placement then apply to each half separately. All configuration inputs are static while a stream runs. The result is registered and appears one clock after the valid input that completes a group.

Top module: `sample_decimator`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_vld` is 0 and `out_data` is 0.
- R2: When `dec_div` is 0 or 1, every valid input produces exactly one output in the following cycle. With signed handling off, that output equals the input word.
- R3: When `dec_div` is N ≥ 2, `out_vld` pulses for one cycle, in the cycle after every N-th valid input. With `avg_en` = 0, the output is the formatted N-th word of the group.
- R4: A cycle with `in_vld` = 0 does not advance the group count and produces no output in the following cycle.
- R5: In full-word mode (`half_mode` = 0) with `sgn_en` = 1, every bit above position `sgn_pos` (0..31) is replaced by bit `sgn_pos`. With `sgn_en` = 0, words are not altered.
- R6: With `avg_en` = 1, the N formatted values of a group are summed in an accumulator 16 bits wider than the sample, so the sum cannot overflow. The sum is then shifted right by ceil(log2 N) bits. The shift is arithmetic when `sgn_en` = 1 and logical otherwise. For a power-of-two N, the result is the floor of the exact mean.
- R7: With `half_mode` = 1, bits 15:0 and bits 31:16 are independent samples. The sign position is `sgn_pos[3:0]` within each half. Averaging is done per half with no carry between halves. The lower-half result occupies bits 15:0 of the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word qualifier |
| in_data | input | 32 | Input sample word |
| dec_div | input | 16 | Decimation divisor N (0 and 1 mean no decimation) |
| avg_en | input | 1 | 1: average each group, 0: keep the last word of each group |
| sgn_pos | input | 5 | Sign bit position |
| sgn_en | input | 1 | 1: signed handling with sign extension |
| half_mode | input | 1 | 1: two 16-bit samples per word |
| out_vld | output | 1 | Output word qualifier |
| out_data | output | 32 | Decimated, formatted word |

## Verification
Sign extension and averaging meet in the same word whenever `sgn_en` and `avg_en` are both set. The shifted mean has to stay inside the sign-extended range, and a wrong choice between arithmetic and logical shift breaks it. The bench provokes this with groups of negative values, both at power-of-two and at non-power-of-two divisors, and in half-word mode with opposite signs in the two lanes. It judges each result against hand-computed means. A bound check also requires each signed output to be a fixed point of sign extension at the configured position.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;
    localparam int DIV_W  = 16;
    localparam int POS_W  = $clog2(WORD_W);
    localparam int SH_W   = $clog2(DIV_W + 1);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             avg;
        logic [POS_W-1:0] pos;
        logic             sgn;
        logic             half;
    } fmt_cfg_t;

    function automatic logic [WORD_W-1:0] sext_word(input logic [WORD_W-1:0] w,
                                                    input logic [POS_W-1:0] p);
        logic [WORD_W-1:0] r;
        r = w;
        for (int i = 0; i < WORD_W; i++)
            if (i > int'(p)) r[i] = w[p];
        return r;
    endfunction

    function automatic logic [HALF_W-1:0] sext_half(input logic [HALF_W-1:0] w,
                                                    input logic [POS_W-2:0] p);
        logic [HALF_W-1:0] r;
        r = w;
        for (int i = 0; i < HALF_W; i++)
            if (i > int'(p)) r[i] = w[p];
        return r;
    endfunction

    // smallest s with 2**s >= n; 0 for n = 0 or 1
    function automatic logic [SH_W-1:0] ceil_log2(input logic [DIV_W-1:0] n);
        logic [SH_W-1:0] s;
        s = '0;
        for (int i = DIV_W; i >= 0; i--)
            if ((33'(1) << i) >= 33'(n)) s = SH_W'(i);
        return s;
    endfunction
endpackage

// File: rtl/dcm_format.sv
module dcm_format
    import dcm_pkg::*;
(
    input  fmt_cfg_t          cfg,
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    always_comb begin
        if (!cfg.sgn)
            dout = din;
        else if (cfg.half)
            dout = {sext_half(din[WORD_W-1:HALF_W], cfg.pos[POS_W-2:0]),
                    sext_half(din[HALF_W-1:0],      cfg.pos[POS_W-2:0])};
        else
            dout = sext_word(din, cfg.pos);
    end
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
    import dcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [DIV_W-1:0] div,
    output logic             first,
    output logic             fire
);
    logic [DIV_W-1:0] cnt;
    logic             bypass;

    assign bypass = (div <= DIV_W'(1));
    assign first  = (cnt == '0);
    assign fire   = take && (bypass || cnt == div - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (take)
            cnt <= fire ? '0 : cnt + DIV_W'(1);
    end
endmodule

// File: rtl/dcm_lane.sv
module dcm_lane
    import dcm_pkg::*;
#(
    parameter int IN_W  = 32,
    parameter int GUARD = 16,
    localparam int ACC_W = IN_W + GUARD
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  logic            first,
    input  logic            sgn,
    input  logic [SH_W-1:0] sh,
    input  logic [IN_W-1:0] x,
    output logic [IN_W-1:0] mean
);
    logic [ACC_W-1:0] acc, ext, sum_now, scaled;

    assign ext     = sgn ? {{GUARD{x[IN_W-1]}}, x} : {{GUARD{1'b0}}, x};
    assign sum_now = first ? ext : acc + ext;
    assign scaled  = sgn ? ACC_W'($signed(sum_now) >>> sh) : (sum_now >> sh);
    assign mean    = scaled[IN_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            acc <= '0;
        else if (take)
            acc <= sum_now;
    end
endmodule

// File: rtl/sample_decimator.sv
module sample_decimator
    import dcm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_data,
    input  logic [DIV_W-1:0]  dec_div,
    input  logic              avg_en,
    input  logic [POS_W-1:0]  sgn_pos,
    input  logic              sgn_en,
    input  logic              half_mode,
    output logic              out_vld,
    output logic [WORD_W-1:0] out_data
);
    fmt_cfg_t          cfg;
    logic [WORD_W-1:0] fmt_word, full_mean, half_mean, pick;
    logic              first, fire;
    logic [SH_W-1:0]   sh;

    assign cfg = '{div: dec_div, avg: avg_en, pos: sgn_pos, sgn: sgn_en, half: half_mode};
    assign sh  = ceil_log2(cfg.div);

    dcm_format u_fmt (.cfg(cfg), .din(in_data), .dout(fmt_word));

    dcm_ctrl u_ctrl (.clk(clk), .rst(rst), .take(in_vld), .div(cfg.div),
                     .first(first), .fire(fire));

    dcm_lane #(.IN_W(WORD_W), .GUARD(DIV_W)) u_full (
        .clk(clk), .rst(rst), .take(in_vld), .first(first), .sgn(cfg.sgn),
        .sh(sh), .x(fmt_word), .mean(full_mean));

    for (genvar g = 0; g < 2; g++) begin : g_half
        dcm_lane #(.IN_W(HALF_W), .GUARD(DIV_W)) u_half (
            .clk(clk), .rst(rst), .take(in_vld), .first(first), .sgn(cfg.sgn),
            .sh(sh), .x(fmt_word[g*HALF_W +: HALF_W]),
            .mean(half_mean[g*HALF_W +: HALF_W]));
    end

    always_comb begin
        if (!cfg.avg)
            pick = fmt_word;
        else if (cfg.half)
            pick = half_mean;
        else
            pick = full_mean;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= fire;
            if (fire) out_data <= pick;
        end
    end
endmodule

// File: rtl/sample_decimator_chk.sv
module sample_decimator_chk
    import dcm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [WORD_W-1:0] in_data,
    input logic [DIV_W-1:0]  dec_div,
    input logic [POS_W-1:0]  sgn_pos,
    input logic              sgn_en,
    input logic              half_mode,
    input logic              out_vld,
    input logic [WORD_W-1:0] out_data
);
    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> (!out_vld && out_data == '0));

    p_pass_every_r2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && dec_div <= DIV_W'(1)) |=> out_vld);

    p_pass_data_r2: assert property (@(posedge clk) disable iff (rst)
        (in_vld && dec_div <= DIV_W'(1) && !sgn_en) |=> (out_data == $past(in_data)));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    p_sext_full_r5: assert property (@(posedge clk) disable iff (rst)
        (out_vld && sgn_en && !half_mode) |-> (out_data == sext_word(out_data, sgn_pos)));

    p_sext_half_r7: assert property (@(posedge clk) disable iff (rst)
        (out_vld && sgn_en && half_mode) |->
        (out_data[HALF_W-1:0] == sext_half(out_data[HALF_W-1:0], sgn_pos[POS_W-2:0]) &&
         out_data[WORD_W-1:HALF_W] == sext_half(out_data[WORD_W-1:HALF_W], sgn_pos[POS_W-2:0])));
endmodule

bind sample_decimator sample_decimator_chk u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .dec_div(dec_div),
    .sgn_pos(sgn_pos), .sgn_en(sgn_en), .half_mode(half_mode),
    .out_vld(out_vld), .out_data(out_data));

// File: tb/sample_decimator_bench.sv
module sample_decimator_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [31:0] in_data = '0;
    logic [15:0] dec_div = '0;
    logic        avg_en = 1'b0;
    logic [4:0]  sgn_pos = '0;
    logic        sgn_en = 1'b0;
    logic        half_mode = 1'b0;
    logic        out_vld;
    logic [31:0] out_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_decimator u_sample_decimator (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data), .dec_div(dec_div),
        .avg_en(avg_en), .sgn_pos(sgn_pos), .sgn_en(sgn_en), .half_mode(half_mode),
        .out_vld(out_vld), .out_data(out_data));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic setup(input logic [15:0] d, input logic a, input logic [4:0] p,
                         input logic s, input logic h);
        @(negedge clk);
        rst = 1'b1; in_vld = 1'b0;
        dec_div = d; avg_en = a; sgn_pos = p; sgn_en = s; half_mode = h;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // drive one valid word; on return the registered result of it is visible
    task automatic push(input logic [31:0] d);
        @(negedge clk);
        in_vld = 1'b1; in_data = d;
        @(negedge clk);
        in_vld = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [31:0] exp);
        check({req, " valid"}, 32'(out_vld), 32'd1);
        check({req, " data"}, out_data, exp);
    endtask

    task automatic expect_none(input string req);
        check({req, " no output"}, 32'(out_vld), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 vld", 32'(out_vld), 32'd0);
        check("R1 data", out_data, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 vld after release", 32'(out_vld), 32'd0);
    endtask

    task automatic t_passthrough;
        setup(16'd0, 1'b0, 5'd0, 1'b0, 1'b0);
        push(32'hDEADBEEF); expect_out("R2 div0", 32'hDEADBEEF);
        push(32'h00000001); expect_out("R2 div0", 32'h00000001);
        setup(16'd1, 1'b1, 5'd0, 1'b0, 1'b0);
        push(32'hCAFEF00D); expect_out("R2 div1 avg", 32'hCAFEF00D);
    endtask

    task automatic t_drop;
        setup(16'd3, 1'b0, 5'd0, 1'b0, 1'b0);
        push(32'd10); expect_none("R3");
        push(32'd11); expect_none("R3");
        @(negedge clk); expect_none("R4 idle");
        @(negedge clk); expect_none("R4 idle");
        push(32'd12); expect_out("R3 third", 32'd12);
        @(negedge clk); expect_none("R3 single pulse");
        push(32'd13); expect_none("R4 count kept");
        push(32'd14); expect_none("R3");
        push(32'd15); expect_out("R3 sixth", 32'd15);
    endtask

    task automatic t_sext;
        setup(16'd0, 1'b0, 5'd7, 1'b1, 1'b0);
        push(32'h00000080); expect_out("R5 neg", 32'hFFFFFF80);
        push(32'h12345670); expect_out("R5 pos", 32'h00000070);
        setup(16'd0, 1'b0, 5'd7, 1'b0, 1'b0);
        push(32'h12345680); expect_out("R5 unsigned", 32'h12345680);
    endtask

    task automatic t_avg;
        setup(16'd4, 1'b1, 5'd31, 1'b1, 1'b0);
        push(32'hFFFFFFFC); push(32'd2); push(32'd6); expect_none("R6");
        push(32'd8); expect_out("R6 signed pow2", 32'd3);
        setup(16'd4, 1'b1, 5'd31, 1'b0, 1'b0);
        push(32'hFFFFFFFF); push(32'hFFFFFFFF); push(32'hFFFFFFFF);
        push(32'hFFFFFFFF); expect_out("R6 unsigned no overflow", 32'hFFFFFFFF);
        setup(16'd3, 1'b1, 5'd31, 1'b0, 1'b0);
        push(32'd4); push(32'd4); push(32'd4); expect_out("R6 div3 shift2", 32'd3);
        setup(16'd3, 1'b1, 5'd31, 1'b1, 1'b0);
        push(32'hFFFFFFFC); push(32'hFFFFFFFC); push(32'hFFFFFFFC);
        expect_out("R6 div3 signed", 32'hFFFFFFFD);
    endtask

    task automatic t_half;
        setup(16'd1, 1'b0, 5'd23, 1'b1, 1'b1);
        push(32'h00800012); expect_out("R7 sext per half", 32'hFF800012);
        setup(16'd2, 1'b1, 5'd15, 1'b1, 1'b1);
        push(32'hFFFE0003); expect_none("R7");
        push(32'hFFFC0005); expect_out("R7 signed avg", 32'hFFFD0004);
        setup(16'd2, 1'b1, 5'd15, 1'b0, 1'b1);
        push(32'h0001FFFF);
        push(32'h0001FFFF); expect_out("R7 no carry", 32'h0001FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_passthrough();
        t_drop();
        t_sext();
        t_avg();
        t_half();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule